// File: doc/BRIEF.md
# HI/LO Integer Multiply-Divide Unit

This block is an iterative 32-bit integer multiplier and divider whose results land in two dedicated result registers, HI and LO, rather than in a general register. Two operands taken from the register file and a two-bit operation code are presented together with a one-cycle start strobe. A multiply leaves its 64-bit product split across the two registers. A divide leaves the quotient and the remainder side by side.

Signed operations first take the operand magnitudes, then run the same unsigned datapath. The datapath does one radix-2 shift-add step per cycle for a multiply and one restoring subtract step per cycle for a divide. The result sign is fixed up on the final cycle. The pipeline outside the block stalls while busy is high, and reads HI and LO through two read ports that always show the last completed result. A divide by zero exits at once with a flag and leaves both registers as they were.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 1 is an unsigned multiply: LO receives bits 31..0 and HI receives bits 63..32 of the 64-bit unsigned product.
- R2: Operation code 0 is a signed multiply: HI:LO receives the 64-bit two's-complement product of the two signed operands.
- R3: Operation code 3 is an unsigned divide: LO receives the quotient and HI receives the remainder.
- R4: Operation code 2 is a signed divide: the quotient rounds toward zero and the remainder carries the sign of the dividend. Dividing -2^31 by -1 gives LO = 0x80000000 and HI = 0.
- R5: An accepted non-zero-divisor start raises busy for exactly 32 cycles after the start edge. done then pulses for one cycle with busy low.
- R6: A start strobe that arrives while busy is high has no effect on the run in progress, on its timing or on its result.
- R7: HI and LO change only in the cycle in which done is high. At all other times they hold the last completed result.
- R8: A divide (code 2 or 3) whose divisor is zero raises done and the divide-by-zero flag together in the cycle after the start edge. It never raises busy and leaves HI and LO unchanged.
- R9: A start strobe presented in the cycle in which done is high is accepted, so operations can run back to back.
- R10: After reset, busy, done and the divide-by-zero flag are low, and HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the clock edge |
| op_i | input | 2 | Operation code: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa_i | input | 32 | First operand (multiplicand or dividend) |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High while an operation iterates |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Divide-by-zero flag, pulses with done |
| hi_o | output | 32 | HI register read port |
| lo_o | output | 32 | LO register read port |

## Verification
The hardest situation to reach from the ports is a second strobe landing inside a run or right at its boundary. Examples are a zero-divisor request that would finish at once if it were accepted, and a new request in the very cycle the previous result appears. The stimulus aims strobes at fixed offsets into a run and at the done cycle. It also mixes zero divisors into the random sequence. The per-cycle reference model then shows that a run is neither cut short nor restarted and that HI/LO keep their values.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // Operation codes: bit 1 selects divide, bit 0 selects unsigned.
    typedef enum logic [1:0] {
        MD_MUL_S = 2'd0,
        MD_MUL_U = 2'd1,
        MD_DIV_S = 2'd2,
        MD_DIV_U = 2'd3
    } md_op_e;

    function automatic logic md_is_div(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic md_is_signed(input logic [1:0] op);
        return !op[0];
    endfunction

endpackage

// File: rtl/muldiv_sign.sv
module muldiv_sign #(
    parameter int W = 32
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_main_o,
    output logic         neg_rem_o
);
    import muldiv_pkg::*;

    logic sgn;
    logic a_neg;
    logic b_neg;

    always_comb begin
        sgn        = md_is_signed(op_i);
        a_neg      = sgn && a_i[W-1];
        b_neg      = sgn && b_i[W-1];
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        neg_main_o = a_neg ^ b_neg;
        neg_rem_o  = a_neg;
    end

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int W = 32
) (
    input  logic         is_div_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] lo_o
);

    logic [W:0] sum;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        // multiply: conditional add then shift the {acc, lo} pair right
        sum     = {1'b0, acc_i} + (lo_i[0] ? {1'b0, opnd_i} : '0);
        // divide: shift the {rem, quotient} pair left then try a subtract
        shifted = {acc_i, lo_i[W-1]};
        trial   = shifted - {1'b0, opnd_i};
        if (is_div_i) begin
            if (!trial[W]) begin
                acc_o = trial[W-1:0];
                lo_o  = {lo_i[W-2:0], 1'b1};
            end else begin
                acc_o = shifted[W-1:0];
                lo_o  = {lo_i[W-2:0], 1'b0};
            end
        end else begin
            acc_o = sum[W:1];
            lo_o  = {sum[0], lo_i[W-1:1]};
        end
    end

endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
    parameter int W = 32
) (
    input  logic         is_div_i,
    input  logic         neg_main_i,
    input  logic         neg_rem_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] lo_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;

    always_comb begin
        prod = {acc_i, lo_i};
        if (neg_main_i) begin
            prod = ~prod + 1'b1;
        end
        quo = neg_main_i ? (~lo_i + 1'b1) : lo_i;
        rem = neg_rem_i ? (~acc_i + 1'b1) : acc_i;
        if (is_div_i) begin
            hi_o = rem;
            lo_o = quo;
        end else begin
            hi_o = prod[PW-1:W];
            lo_o = prod[W-1:0];
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         dz_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    import muldiv_pkg::*;

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             dz;
        logic             is_div;
        logic             neg_main;
        logic             neg_rem;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     acc;
        logic [W-1:0]     work;
        logic [W-1:0]     opnd;
        logic [W-1:0]     hi;
        logic [W-1:0]     lo;
    } md_state_t;

    md_state_t st_d, st_q;

    logic [W-1:0] mag_a, mag_b;
    logic         in_neg_main, in_neg_rem;
    logic [W-1:0] step_acc, step_work;
    logic [W-1:0] fin_hi, fin_lo;

    muldiv_sign #(.W(W)) u_sign (
        .op_i       (op_i),
        .a_i        (opa_i),
        .b_i        (opb_i),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_main_o (in_neg_main),
        .neg_rem_o  (in_neg_rem)
    );

    muldiv_step #(.W(W)) u_step (
        .is_div_i (st_q.is_div),
        .acc_i    (st_q.acc),
        .lo_i     (st_q.work),
        .opnd_i   (st_q.opnd),
        .acc_o    (step_acc),
        .lo_o     (step_work)
    );

    muldiv_fix #(.W(W)) u_fix (
        .is_div_i   (st_q.is_div),
        .neg_main_i (st_q.neg_main),
        .neg_rem_i  (st_q.neg_rem),
        .acc_i      (step_acc),
        .lo_i       (step_work),
        .hi_o       (fin_hi),
        .lo_o       (fin_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.dz   = 1'b0;
        if (st_q.busy) begin
            st_d.acc  = step_acc;
            st_d.work = step_work;
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.hi   = fin_hi;
                st_d.lo   = fin_lo;
            end
        end else if (start_i) begin
            if (md_is_div(op_i) && (opb_i == '0)) begin
                st_d.done = 1'b1;
                st_d.dz   = 1'b1;
            end else begin
                st_d.busy     = 1'b1;
                st_d.cnt      = STEPS;
                st_d.is_div   = md_is_div(op_i);
                st_d.neg_main = in_neg_main;
                st_d.neg_rem  = in_neg_rem;
                st_d.acc      = '0;
                st_d.work     = mag_a;
                st_d.opnd     = mag_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign dz_o   = st_q.dz;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         dz_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);

    localparam int LW = $clog2(W + 2);

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R5

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_o) |-> (run_len == LW'(W))); // R5

    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (run_len < LW'(W - 1))) |=> busy_o); // R6

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o))); // R7

    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> done_o); // R8

    AST_DZ_KEEPS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> ($stable(hi_o) && $stable(lo_o))); // R8

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o || dz_o)); // R9

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .dz_o    (dz_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         busy, done, dz;
    logic [W-1:0] hi, lo;

    always #2 clk = ~clk;

    muldiv_hilo #(.W(W)) u_muldiv_hilo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .op_i    (op),
        .opa_i   (a),
        .opb_i   (b),
        .busy_o  (busy),
        .done_o  (done),
        .dz_o    (dz),
        .hi_o    (hi),
        .lo_o    (lo)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- reference model ----------------
    bit          m_busy, m_done, m_dz;
    int          m_cnt;
    logic [31:0] m_hi, m_lo, p_hi, p_lo;
    string       m_tag = "R10";
    string       p_tag = "R10";

    task automatic ref_calc(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                            output logic [31:0] rh, output logic [31:0] rl, output string t);
        longint      sp, sx, sy, q, r;
        logic [63:0] up;
        case (o)
            2'd0: begin
                sp = longint'($signed(x)) * longint'($signed(y));
                rh = sp[63:32]; rl = sp[31:0]; t = "R2";
            end
            2'd1: begin
                up = {32'b0, x} * {32'b0, y};
                rh = up[63:32]; rl = up[31:0]; t = "R1";
            end
            2'd2: begin
                sx = longint'($signed(x)); sy = longint'($signed(y));
                q = sx / sy; r = sx % sy;
                rh = r[31:0]; rl = q[31:0]; t = "R4";
            end
            default: begin
                rh = x % y; rl = x / y; t = "R3";
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_cnt = 0;
            m_hi = '0; m_lo = '0; m_tag = "R10";
        end else begin
            m_done = 0; m_dz = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_hi = p_hi; m_lo = p_lo; m_tag = p_tag;
                end
            end else if (start) begin
                if (op[1] && b == 0) begin
                    m_done = 1; m_dz = 1;
                end else begin
                    m_busy = 1; m_cnt = 32;
                    ref_calc(op, a, b, p_hi, p_lo, p_tag);
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5", "busy", 32'(busy), 32'(m_busy));
            chk("R5", "done", 32'(done), 32'(m_done));
            chk("R8", "dz", 32'(dz), 32'(m_dz));
            chk(m_done ? m_tag : "R7", "hi", hi, m_hi);
            chk(m_done ? m_tag : "R7", "lo", lo, m_lo);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        start = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        pulse(o, x, y);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "busy in reset", 32'(busy), 32'd0);
        chk("R10", "done in reset", 32'(done), 32'd0);
        chk("R10", "dz in reset", 32'(dz), 32'd0);
        chk("R10", "hi in reset", hi, 32'd0);
        chk("R10", "lo in reset", lo, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 unsigned multiply
        run(2'd1, 32'd3, 32'd5);
        run(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run(2'd1, 32'h8000_0000, 32'd2);
        // R2 signed multiply
        run(2'd0, -32'sd3, 32'sd7);
        run(2'd0, 32'h8000_0000, 32'h8000_0000);
        run(2'd0, -32'sd1, -32'sd1);
        run(2'd0, 32'h7FFF_FFFF, -32'sd1);
        // R3 unsigned divide
        run(2'd3, 32'd100, 32'd7);
        run(2'd3, 32'hFFFF_FFFF, 32'd1);
        run(2'd3, 32'd5, 32'd10);
        run(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R4 signed divide
        run(2'd2, -32'sd7, 32'sd2);
        run(2'd2, 32'sd7, -32'sd2);
        run(2'd2, -32'sd7, -32'sd2);
        run(2'd2, 32'h8000_0000, -32'sd1);
        // R8 divide by zero leaves HI/LO
        run(2'd3, 32'd5, 32'd0);
        run(2'd2, -32'sd5, 32'd0);

        // R6: strobes during a run, including one with a zero divisor
        pulse(2'd1, 32'd6, 32'd7);
        repeat (4) @(negedge clk);
        pulse(2'd3, 32'd9, 32'd0);
        repeat (10) @(negedge clk);
        pulse(2'd2, 32'd100, 32'd3);
        while (busy) @(negedge clk);
        @(negedge clk);

        // R9: new start in the done cycle, then again for a zero divisor
        pulse(2'd1, 32'd2, 32'd3);
        while (busy) @(negedge clk);
        start = 1'b1; op = 2'd3; a = 32'd50; b = 32'd7;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        start = 1'b1; op = 2'd2; a = 32'd1; b = 32'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);

        // mixed random operations
        for (int i = 0; i < 40; i++) begin
            logic [31:0] x, y;
            x = $urandom;
            y = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
            if ($urandom_range(0, 3) == 0) y = y >> $urandom_range(0, 31);
            run(2'($urandom_range(0, 3)), x, y);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule